// File: doc/BRIEF.md
# DMA Channel Request Qualifier and Arbiter

This block sits between a DMA controller's per-channel settings and its transfer engine. Each cycle it looks at every channel's peripheral request lines (a single-transfer line and a burst line) and at software-raised requests. It removes the requests that the channel's settings forbid: a global enable, a per-channel enable, a request mask and a burst-only mode. From the channels that remain it picks one. Channels marked urgent win over normal ones, and within a level the lowest channel number wins.

The grant is registered. It names the channel, says whether the grant is a burst or a single, and gives the beat count: 2^R for a burst, where R is a per-channel rate field, and 1 for a single. The engine then reports each moved beat, or ends the transfer early. The grant is held until the last beat or the early end, and a new choice is made afterwards. A channel can be set to stay active after its grant ends until its request lines have dropped. This serves requesters in slower or unrelated clock domains.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant_valid` is 0 and `ch_active` is all zeros.
- R2: A channel whose `req_mask` bit is 1 is never granted because of `per_single` or `per_burst`. A pending software request on that channel is still served.
- R3: A channel whose `burst_only` bit is 1 ignores `per_single`. Its `per_burst` request is granted with `grant_burst`=1 and `grant_beats` = 2^R, where R is the channel's field `rate_sel[ch*RATE_W +: RATE_W]`.
- R4: A channel whose `burst_only` bit is 0 is granted a single (`grant_burst`=0, `grant_beats`=1) when only `per_single` is high. It is granted a burst of 2^R beats when `per_burst` is high, and this applies whether or not `per_single` is also high.
- R5: If any candidate has its `hi_prio` bit set, the lowest-numbered such candidate wins. Otherwise the lowest-numbered candidate wins. `grant_ch` is the binary channel index.
- R6: Only channels with their `ch_en` bit set, and only while `glob_en` is 1, can be granted.
- R7: A cycle with `sw_wr`=1 and `sw_ch` below NCH leaves one pending request on that channel. The request is served once as a burst of 2^R beats and is then gone. A `sw_ch` value of NCH or more creates nothing.
- R8: A grant appears at the clock edge after a candidate is visible while no grant is held. It stays unchanged until the edge where `xfer_end` is seen, or where `beat_done` is seen for the last of `grant_beats` beats. `grant_valid` is 0 after that edge.
- R9: When a grant ends on a channel whose `hold_req` bit is 1 while either of its request lines is high, that channel keeps its `ch_active` bit and cannot be granted until both lines are low. With `hold_req`=0 the channel leaves `ch_active` at once and may be granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Controller-wide enable |
| ch_en | input | NCH | Per-channel enable |
| req_mask | input | NCH | Per-channel peripheral request mask |
| burst_only | input | NCH | Per-channel burst-only mode |
| hi_prio | input | NCH | Per-channel urgent priority |
| hold_req | input | NCH | Per-channel stay-active-until-request-drops mode |
| rate_sel | input | NCH*RATE_W | Per-channel rate R, channel c at bits c*RATE_W upward |
| per_single | input | NCH | Peripheral single-transfer request lines |
| per_burst | input | NCH | Peripheral burst request lines |
| sw_wr | input | 1 | Software request strobe |
| sw_ch | input | IDX_W | Channel index of the software request |
| beat_done | input | 1 | Engine has moved one beat of the current grant |
| xfer_end | input | 1 | Engine ends the current grant early |
| grant_valid | output | 1 | A grant is held |
| grant_ch | output | CW | Granted channel index |
| grant_burst | output | 1 | 1 for a burst grant, 0 for a single |
| grant_beats | output | 2^RATE_W | Beats in the current grant |
| ch_active | output | NCH | Channel currently granted or held waiting for its request to drop |

## Verification
The bench builds the block with NCH=4, RATE_W=3 and IDX_W=5. Four channels make every combination of enable and priority pattern (16 by 16) small enough to sweep in full, with the expected winner worked out arithmetically. Three rate bits give bursts of up to 128 beats, so every R value can be counted out beat by beat on every channel. The five-bit software index allows values such as 6 and 20, which do not name any channel and exercise the "creates nothing" rule.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int unsigned MAX_CH = 32;

  // Index of the least significant set bit, 0 when none is set.
  function automatic int unsigned lowest_set(input logic [MAX_CH-1:0] v);
    lowest_set = 0;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (v[i]) lowest_set = i;
    end
  endfunction

  // Beats granted for one arbitration: 2^r for bursts, one otherwise.
  function automatic int unsigned beat_count(input logic is_burst, input int unsigned r);
    beat_count = is_burst ? (32'd1 << r) : 32'd1;
  endfunction

endpackage

// File: rtl/dma_req_qualify.sv
module dma_req_qualify #(
  parameter int NCH   = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glob_en,
  input  logic [NCH-1:0]   ch_en,
  input  logic [NCH-1:0]   req_mask,
  input  logic [NCH-1:0]   burst_only,
  input  logic [NCH-1:0]   per_single,
  input  logic [NCH-1:0]   per_burst,
  input  logic [NCH-1:0]   hold_vec,
  input  logic             sw_wr,
  input  logic [IDX_W-1:0] sw_ch,
  input  logic [NCH-1:0]   take_vec,
  output logic [NCH-1:0]   cand,
  output logic [NCH-1:0]   cand_burst
);

  logic [NCH-1:0] sw_pend;
  logic [NCH-1:0] burst_ok;
  logic [NCH-1:0] single_ok;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // A strobe only hits implemented channels; larger indices match nothing.
    logic sw_hit;
    assign sw_hit = sw_wr && (sw_ch == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           sw_pend[i] <= 1'b0;
      else if (sw_hit)      sw_pend[i] <= 1'b1;
      else if (take_vec[i]) sw_pend[i] <= 1'b0;
    end

    always_comb begin
      burst_ok[i]   = per_burst[i] && !req_mask[i];
      single_ok[i]  = per_single[i] && !req_mask[i] && !burst_only[i];
      cand[i]       = glob_en && ch_en[i] && !hold_vec[i] &&
                      (burst_ok[i] || single_ok[i] || sw_pend[i]);
      cand_burst[i] = burst_ok[i] || sw_pend[i];
    end

    p_mask_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_mask[i] && !sw_pend[i]) |-> !cand[i]);

    p_single_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_only[i] && !per_burst[i] && !sw_pend[i]) |-> !cand[i]);

    p_disabled_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en || !ch_en[i]) |-> !cand[i]);
  end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cand,
  input  logic [NCH-1:0] hi_prio,
  output logic           win_valid,
  output logic [CW-1:0]  win_ch,
  output logic [NCH-1:0] win_onehot
);
  import dma_arb_pkg::*;

  logic [NCH-1:0]    hi_cand;
  logic [NCH-1:0]    pool;
  logic [MAX_CH-1:0] pool_wide;

  always_comb begin
    hi_cand   = cand & hi_prio;
    pool      = (|hi_cand) ? hi_cand : cand;
    pool_wide = '0;
    pool_wide[NCH-1:0] = pool;
    win_valid  = |cand;
    win_ch     = CW'(lowest_set(pool_wide));
    win_onehot = win_valid ? (NCH'(1) << win_ch) : '0;
  end

  p_winner_is_cand_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> cand[win_ch]);

  p_urgent_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && (|(cand & hi_prio))) |-> hi_prio[win_ch]);

endmodule

// File: rtl/dma_grant_ctrl.sv
module dma_grant_ctrl #(
  parameter int NCH    = 8,
  parameter int CW     = 3,
  parameter int RATE_W = 4,
  parameter int BEAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_valid,
  input  logic [CW-1:0]     win_ch,
  input  logic              win_burst,
  input  logic [RATE_W-1:0] win_rate,
  input  logic              beat_done,
  input  logic              xfer_end,
  input  logic [NCH-1:0]    line_any,
  input  logic [NCH-1:0]    hold_req,
  output logic              gv,
  output logic [CW-1:0]     gch,
  output logic              gburst,
  output logic [BEAT_W-1:0] gbeats,
  output logic [NCH-1:0]    hold_vec,
  output logic              start,
  output logic              stop
);
  import dma_arb_pkg::*;

  logic [BEAT_W-1:0] remaining;
  logic [BEAT_W-1:0] load_beats;

  always_comb begin
    load_beats = BEAT_W'(beat_count(win_burst, int'(win_rate)));
    start      = win_valid && !gv;
    stop       = gv && (xfer_end || (beat_done && remaining == BEAT_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv        <= 1'b0;
      gch       <= '0;
      gburst    <= 1'b0;
      gbeats    <= '0;
      remaining <= '0;
    end else if (start) begin
      gv        <= 1'b1;
      gch       <= win_ch;
      gburst    <= win_burst;
      gbeats    <= load_beats;
      remaining <= load_beats;
    end else if (stop) begin
      gv        <= 1'b0;
    end else if (gv && beat_done) begin
      remaining <= remaining - BEAT_W'(1);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        hold_vec[i] <= 1'b0;
      else if (stop && gch == CW'(i))    hold_vec[i] <= hold_req[i] && line_any[i];
      else if (!line_any[i])             hold_vec[i] <= 1'b0;
    end

    p_hold_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_vec[i] && !line_any[i]) |=> !hold_vec[i]);
  end

  p_grant_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gv && !xfer_end && !beat_done) |=> (gv && $stable(gch) && $stable(gbeats)));

  p_stop_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !gv);

  p_single_one_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gv && !gburst) |-> gbeats == BEAT_W'(1));

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter  int NCH    = 8,
  parameter  int RATE_W = 4,
  parameter  int IDX_W  = 5,
  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BEAT_W = 1 << RATE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glob_en,
  input  logic [NCH-1:0]        ch_en,
  input  logic [NCH-1:0]        req_mask,
  input  logic [NCH-1:0]        burst_only,
  input  logic [NCH-1:0]        hi_prio,
  input  logic [NCH-1:0]        hold_req,
  input  logic [NCH*RATE_W-1:0] rate_sel,
  input  logic [NCH-1:0]        per_single,
  input  logic [NCH-1:0]        per_burst,
  input  logic                  sw_wr,
  input  logic [IDX_W-1:0]      sw_ch,
  input  logic                  beat_done,
  input  logic                  xfer_end,
  output logic                  grant_valid,
  output logic [CW-1:0]         grant_ch,
  output logic                  grant_burst,
  output logic [BEAT_W-1:0]     grant_beats,
  output logic [NCH-1:0]        ch_active
);

  logic [NCH-1:0]    cand, cand_burst, hold_vec, take_vec, win_onehot, line_any;
  logic              win_valid, win_burst, start, stop;
  logic [CW-1:0]     win_ch;
  logic [RATE_W-1:0] win_rate;

  always_comb begin
    line_any  = per_single | per_burst;
    win_burst = cand_burst[win_ch];
    win_rate  = rate_sel[int'(win_ch) * RATE_W +: RATE_W];
    take_vec  = start ? win_onehot : '0;
    ch_active = hold_vec | (grant_valid ? (NCH'(1) << grant_ch) : '0);
  end

  dma_req_qualify #(.NCH(NCH), .IDX_W(IDX_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .ch_en(ch_en),
    .req_mask(req_mask), .burst_only(burst_only),
    .per_single(per_single), .per_burst(per_burst), .hold_vec(hold_vec),
    .sw_wr(sw_wr), .sw_ch(sw_ch), .take_vec(take_vec),
    .cand(cand), .cand_burst(cand_burst)
  );

  dma_prio_pick #(.NCH(NCH), .CW(CW)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand(cand), .hi_prio(hi_prio),
    .win_valid(win_valid), .win_ch(win_ch), .win_onehot(win_onehot)
  );

  dma_grant_ctrl #(.NCH(NCH), .CW(CW), .RATE_W(RATE_W), .BEAT_W(BEAT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ch(win_ch),
    .win_burst(win_burst), .win_rate(win_rate), .beat_done(beat_done),
    .xfer_end(xfer_end), .line_any(line_any), .hold_req(hold_req),
    .gv(grant_valid), .gch(grant_ch), .gburst(grant_burst),
    .gbeats(grant_beats), .hold_vec(hold_vec), .start(start), .stop(stop)
  );

  p_held_not_picked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !hold_vec[win_ch]);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> $past(win_valid));

endmodule

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;
  localparam int NCH = 4, RATE_W = 3, IDX_W = 5;
  localparam int CW = 2, BEAT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic glob_en = 0, sw_wr = 0, beat_done = 0, xfer_end = 0;
  logic [NCH-1:0] ch_en = 0, req_mask = 0, burst_only = 0, hi_prio = 0;
  logic [NCH-1:0] hold_req = 0, per_single = 0, per_burst = 0;
  logic [NCH*RATE_W-1:0] rate_sel = 0;
  logic [IDX_W-1:0] sw_ch = 0;
  logic grant_valid, grant_burst;
  logic [CW-1:0] grant_ch;
  logic [BEAT_W-1:0] grant_beats;
  logic [NCH-1:0] ch_active;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_req_arbiter #(.NCH(NCH), .RATE_W(RATE_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .ch_en(ch_en),
    .req_mask(req_mask), .burst_only(burst_only), .hi_prio(hi_prio),
    .hold_req(hold_req), .rate_sel(rate_sel), .per_single(per_single),
    .per_burst(per_burst), .sw_wr(sw_wr), .sw_ch(sw_ch),
    .beat_done(beat_done), .xfer_end(xfer_end), .grant_valid(grant_valid),
    .grant_ch(grant_ch), .grant_burst(grant_burst),
    .grant_beats(grant_beats), .ch_active(ch_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // Ends the current grant early and drops all peripheral lines.
  task automatic release_all();
    per_single = 0; per_burst = 0; xfer_end = 1;
    tick();
    xfer_end = 0;
  endtask

  function automatic int expect_win(input int en, input int hi);
    int pool = ((en & hi) != 0) ? (en & hi) : en;
    for (int i = 0; i < NCH; i++) if (pool[i]) return i;
    return 0;
  endfunction

  initial begin
    tick(3);
    chk("R1 grant_valid after reset", int'(grant_valid), 0);
    chk("R1 ch_active after reset", int'(ch_active), 0);
    rst_n = 1; glob_en = 1; ch_en = 4'hF;
    tick();
    chk("R1 idle with no requests", int'(grant_valid), 0);

    // R4: single requests on every channel give one-beat single grants.
    for (int c = 0; c < NCH; c++) begin
      per_single = NCH'(1 << c);
      tick();
      chk("R4 single valid", int'(grant_valid), 1);
      chk("R4 single channel", int'(grant_ch), c);
      chk("R4 single kind", int'(grant_burst), 0);
      chk("R4 single beats", int'(grant_beats), 1);
      chk("R9 active while granted", int'(ch_active), 1 << c);
      per_single = 0; beat_done = 1;
      tick();
      beat_done = 0;
      chk("R8 single ends after one beat", int'(grant_valid), 0);
    end

    // R3: burst-only channels, every rate, counted beat by beat.
    burst_only = 4'hF;
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < (1 << RATE_W); r++) begin
        rate_sel = {NCH{RATE_W'(r)}};
        per_single = NCH'(1 << c);
        tick(2);
        chk("R3 single ignored", int'(grant_valid), 0);
        per_burst = NCH'(1 << c);
        tick();
        chk("R3 burst channel", int'(grant_ch), c);
        chk("R3 burst kind", int'(grant_burst), 1);
        chk("R3 burst beats", int'(grant_beats), 1 << r);
        per_single = 0; per_burst = 0; beat_done = 1;
        if (r > 0) begin
          tick((1 << r) - 1);
          chk("R8 grant held before last beat", int'(grant_valid), 1);
        end
        tick();
        beat_done = 0;
        chk("R8 grant ends at last beat", int'(grant_valid), 0);
      end
    end
    burst_only = 0;

    // R4: both lines high without burst-only gives a burst; R8 early end.
    rate_sel = {NCH{3'd3}};
    per_single = 4'b0100; per_burst = 4'b0100;
    tick();
    chk("R4 both lines burst kind", int'(grant_burst), 1);
    chk("R4 both lines beats", int'(grant_beats), 8);
    beat_done = 1; tick(2); beat_done = 0;
    chk("R8 mid-burst still held", int'(grant_valid), 1);
    release_all();
    chk("R8 early end drops grant", int'(grant_valid), 0);

    // R2: masked lines ignored, software request still served (R7).
    req_mask = 4'hF; per_single = 4'hF; per_burst = 4'hF;
    tick(2);
    chk("R2 masked lines ignored", int'(grant_valid), 0);
    rate_sel = {NCH{3'd2}};
    sw_wr = 1; sw_ch = 5'd3;
    tick();
    sw_wr = 0;
    tick();
    chk("R7 software grant channel", int'(grant_ch), 3);
    chk("R7 software grant valid", int'(grant_valid), 1);
    chk("R7 software burst beats", int'(grant_beats), 4);
    release_all();
    req_mask = 0;
    tick(2);
    chk("R7 software request is one-shot", int'(grant_valid), 0);

    // R7: indices beyond the channel count create nothing.
    sw_wr = 1; sw_ch = 5'd6; tick();
    sw_ch = 5'd20; tick();
    sw_wr = 0; tick(2);
    chk("R7 unimplemented index grant", int'(grant_valid), 0);
    chk("R7 unimplemented index active", int'(ch_active), 0);

    // R6: channel enables and the global enable.
    ch_en = 0; per_single = 4'hF;
    tick(2);
    chk("R6 channels disabled", int'(grant_valid), 0);
    ch_en = 4'hF; glob_en = 0;
    tick(2);
    chk("R6 global disable", int'(grant_valid), 0);
    per_single = 0; glob_en = 1;
    tick();

    // R5: every enable pattern against every urgency pattern.
    for (int hi = 0; hi < 16; hi++) begin
      for (int en = 1; en < 16; en++) begin
        ch_en = NCH'(en); hi_prio = NCH'(hi); per_single = 4'hF;
        tick();
        chk("R5 winner valid", int'(grant_valid), 1);
        chk("R5 winner channel", int'(grant_ch), expect_win(en, hi));
        release_all();
      end
    end
    ch_en = 4'hF; hi_prio = 0;
    tick();

    // R9: hold until the request drops.
    hold_req = 4'b0010; per_single = 4'b0010;
    tick();
    chk("R9 hold channel granted", int'(grant_ch), 1);
    beat_done = 1; tick(); beat_done = 0;
    chk("R9 grant ended", int'(grant_valid), 0);
    chk("R9 held channel still active", int'(ch_active), 4'b0010);
    tick(2);
    chk("R9 held channel not regranted", int'(grant_valid), 0);
    per_burst = 4'b0100;
    tick();
    chk("R9 other channel granted while held", int'(grant_ch), 2);
    chk("R9 active shows both", int'(ch_active), 4'b0110);
    per_burst = 0; xfer_end = 1; tick(); xfer_end = 0;
    chk("R9 hold kept while line high", int'(ch_active), 4'b0010);
    per_single = 0;
    tick();
    chk("R9 hold released when line drops", int'(ch_active), 0);
    hold_req = 0; per_single = 4'b0010;
    tick();
    beat_done = 1; tick(); beat_done = 0;
    chk("R9 no hold leaves active", int'(ch_active), 0);
    tick();
    chk("R9 no hold regrant", int'(grant_valid), 1);
    chk("R9 no hold regrant channel", int'(grant_ch), 1);
    release_all();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule